// File: doc/BRIEF.md
# Paged NIC Register Bank with Interrupt

This block is the byte-wide host register bank of a simple Ethernet controller. A host reaches it through a 4-bit address. Offset 0 is always the command register. The two top bits of the command register select one of four pages for every other offset. Reads and writes at the same offset can reach different registers. The bank holds the receive ring bounds, the boundary and current pages, the transmit page and length, the remote DMA address and count, the receive and data configuration bytes, the six-byte station address, the 64-bit multicast hash, the interrupt status and the interrupt mask. The stored values are presented on plain output buses for the engines that sit around the bank.

Receive, transmit and DMA engines report events through a 7-bit set vector, and the bank combines status with mask into one level interrupt. A command write can have side effects. With stop clear, it starts a transmit: a one-cycle send strobe carries the start address and length, and the transmit completion is recorded. With stop clear and a zero remote count, a remote read or write request is marked complete at once. Reads are combinational and have no side effects.

Top module: `nic_regbank`

## Requirements
- R1: After reset the command register reads 0x00, the status register reads 0x80, the mask is 0, `irq` is low, `tx_go` is low, and every other stored value is 0.
- R2: Offset 0 always addresses the command register. Any other offset `a` addresses register index {cmd[7:6], a}. Page 1 holds the station address bytes at 0x1..0x6, with the byte at offset 0x1 on `station_addr[7:0]`, the current page at 0x7, and the hash bytes at 0x8..0xf, with offset 0x8 on `mcast_hash[7:0]`. A write made on page 1 never changes a page 0 register.
- R3: `irq` is high exactly when (status AND mask) has a 1 in bits 6:0. Status bit 7 never raises `irq`.
- R4: A write to page 0 offset 0x7 clears every status bit 6:0 where the written byte has a 1. Status bit 7 is unaffected by this write.
- R5: A command write with bit 0 (stop) clear clears status bit 7. A command write with stop set leaves status bit 7 unchanged.
- R6: A command write with stop clear that sets bit 3 (remote read) or bit 4 (remote write) while the remote count is zero sets status bit 6. It leaves bit 6 alone when the count is nonzero or when stop is set.
- R7: A command write with stop clear and bit 2 set gives a one-cycle `tx_go` in the cycle after the write, with `tx_addr` = transmit page × 256 and `tx_len` = the programmed count. In the same cycle status bit 1 is set, the transmit status (page 0 offset 0x4) reads 0x01, and the stored command has bit 2 cleared.
- R8: The transmit count (page 0 offsets 0x5 low and 0x6 high), the remote address (0x8 low and 0x9 high) and the remote count (0xa low and 0xb high) are loaded one byte at a time. Each write changes only its own half.
- R9: Page 0 offsets 0xa and 0xb read 0x50 and 0x43. Every read location without a register behind it returns 0. This includes page 0 offsets 0x1, 0x2 and 0xc, and all of page 3.
- R10: Page 0 offsets 0x1 and 0x2 store the ring start and stop pages. They appear on `ring_start` and `ring_stop` as page × 256, and page 2 offsets 0x1 and 0x2 read them back as page numbers.
- R11: Each 1 in `evt_set` sets the matching status bit 6:0 on the next edge. The bits are: 0 receive ok, 1 transmit ok, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counter overflow, 6 remote DMA complete. A set wins over a host clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for one cycle |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for host_addr |
| evt_set | input | 7 | Engine event pulses, set status bits 6:0 |
| irq | output | 1 | Level interrupt |
| tx_go | output | 1 | One-cycle send strobe |
| tx_addr | output | 16 | Send start byte address |
| tx_len | output | 16 | Send length in bytes |
| ring_start | output | 16 | Ring start byte address |
| ring_stop | output | 16 | Ring stop byte address |
| dma_addr | output | 16 | Remote DMA address |
| dma_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |
| station_addr | output | 48 | Station address, first byte in bits 7:0 |
| mcast_hash | output | 64 | Multicast hash table |

## Verification
The bench builds the bank with its default identification bytes, 0x50 and 0x43. With those values and all 64 page/offset slots fixed, it can read the complete map straight after reset and compare each slot with an arithmetic model. Because the status register has only seven clearable bits and the mask has eight, the bench sweeps all 128 clear patterns and all 256 mask values against several status patterns, so every combination of clear and interrupt gating is covered.

// File: rtl/nic_regbank.sv
module nic_regbank #(
  parameter logic [7:0] ID_LO = 8'h50,
  parameter logic [7:0] ID_HI = 8'h43
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic [6:0]  evt_set,
  output logic        irq,
  output logic        tx_go,
  output logic [15:0] tx_addr,
  output logic [15:0] tx_len,
  output logic [15:0] ring_start,
  output logic [15:0] ring_stop,
  output logic [15:0] dma_addr,
  output logic [15:0] dma_count,
  output logic [7:0]  rx_cfg,
  output logic [7:0]  data_cfg,
  output logic [47:0] station_addr,
  output logic [63:0] mcast_hash
);

  logic [7:0]  cmd_q, start_q, stop_q, bnd_q, tsr_q, tpsr_q;
  logic [7:0]  rxcr_q, dcfg_q, imr_q, isr_q, isr_n, cur_q;
  logic [15:0] tcnt_q, rsar_q, rcnt_q;
  logic [5:0][7:0] sta_q;
  logic [7:0][7:0] mch_q;
  logic        tx_go_q;
  logic [15:0] tx_addr_q, tx_len_q;

  wire       cmd_wr   = host_wr && (host_addr == 4'd0);
  wire       reg_wr   = host_wr && (host_addr != 4'd0);
  wire [5:0] idx      = {cmd_q[7:6], host_addr};
  wire       run_cmd  = cmd_wr && !host_wdata[0];
  wire       tx_req   = run_cmd && host_wdata[2];
  wire       dma_zero = run_cmd && (host_wdata[3] || host_wdata[4]) && (rcnt_q == 16'd0);

  always_comb begin
    isr_n = isr_q;
    if (reg_wr && idx == 6'h07) isr_n[6:0] = isr_q[6:0] & ~host_wdata[6:0];
    if (run_cmd)  isr_n[7] = 1'b0;
    if (dma_zero) isr_n[6] = 1'b1;
    if (tx_req)   isr_n[1] = 1'b1;
    isr_n[6:0] = isr_n[6:0] | evt_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q     <= 8'h80;
      cmd_q     <= '0;
      tsr_q     <= '0;
      tx_go_q   <= 1'b0;
      tx_addr_q <= '0;
      tx_len_q  <= '0;
    end else begin
      isr_q   <= isr_n;
      tx_go_q <= tx_req;
      if (cmd_wr) cmd_q <= tx_req ? (host_wdata & 8'hfb) : host_wdata;
      if (tx_req) begin
        tsr_q     <= 8'h01;
        tx_addr_q <= {tpsr_q, 8'h00};
        tx_len_q  <= tcnt_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0; stop_q <= '0; bnd_q <= '0; tpsr_q <= '0;
      tcnt_q  <= '0; rsar_q <= '0; rcnt_q <= '0;
      rxcr_q  <= '0; dcfg_q <= '0; imr_q <= '0; cur_q <= '0;
      sta_q   <= '0; mch_q  <= '0;
    end else if (reg_wr) begin
      case (idx)
        6'h01: start_q       <= host_wdata;
        6'h02: stop_q        <= host_wdata;
        6'h03: bnd_q         <= host_wdata;
        6'h04: tpsr_q        <= host_wdata;
        6'h05: tcnt_q[7:0]   <= host_wdata;
        6'h06: tcnt_q[15:8]  <= host_wdata;
        6'h08: rsar_q[7:0]   <= host_wdata;
        6'h09: rsar_q[15:8]  <= host_wdata;
        6'h0a: rcnt_q[7:0]   <= host_wdata;
        6'h0b: rcnt_q[15:8]  <= host_wdata;
        6'h0c: rxcr_q        <= host_wdata;
        6'h0e: dcfg_q        <= host_wdata;
        6'h0f: imr_q         <= host_wdata;
        6'h11: sta_q[0]      <= host_wdata;
        6'h12: sta_q[1]      <= host_wdata;
        6'h13: sta_q[2]      <= host_wdata;
        6'h14: sta_q[3]      <= host_wdata;
        6'h15: sta_q[4]      <= host_wdata;
        6'h16: sta_q[5]      <= host_wdata;
        6'h17: cur_q         <= host_wdata;
        6'h18: mch_q[0]      <= host_wdata;
        6'h19: mch_q[1]      <= host_wdata;
        6'h1a: mch_q[2]      <= host_wdata;
        6'h1b: mch_q[3]      <= host_wdata;
        6'h1c: mch_q[4]      <= host_wdata;
        6'h1d: mch_q[5]      <= host_wdata;
        6'h1e: mch_q[6]      <= host_wdata;
        6'h1f: mch_q[7]      <= host_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == 4'd0) host_rdata = cmd_q;
    else begin
      case (idx)
        6'h03: host_rdata = bnd_q;
        6'h04: host_rdata = tsr_q;
        6'h07: host_rdata = isr_q;
        6'h08: host_rdata = rsar_q[7:0];
        6'h09: host_rdata = rsar_q[15:8];
        6'h0a: host_rdata = ID_LO;
        6'h0b: host_rdata = ID_HI;
        6'h11: host_rdata = sta_q[0];
        6'h12: host_rdata = sta_q[1];
        6'h13: host_rdata = sta_q[2];
        6'h14: host_rdata = sta_q[3];
        6'h15: host_rdata = sta_q[4];
        6'h16: host_rdata = sta_q[5];
        6'h17: host_rdata = cur_q;
        6'h18: host_rdata = mch_q[0];
        6'h19: host_rdata = mch_q[1];
        6'h1a: host_rdata = mch_q[2];
        6'h1b: host_rdata = mch_q[3];
        6'h1c: host_rdata = mch_q[4];
        6'h1d: host_rdata = mch_q[5];
        6'h1e: host_rdata = mch_q[6];
        6'h1f: host_rdata = mch_q[7];
        6'h21: host_rdata = start_q;
        6'h22: host_rdata = stop_q;
        default: host_rdata = 8'h00;
      endcase
    end
  end

  assign irq          = |(isr_q[6:0] & imr_q[6:0]);
  assign tx_go        = tx_go_q;
  assign tx_addr      = tx_addr_q;
  assign tx_len       = tx_len_q;
  assign ring_start   = {start_q, 8'h00};
  assign ring_stop    = {stop_q, 8'h00};
  assign dma_addr     = rsar_q;
  assign dma_count    = rcnt_q;
  assign rx_cfg       = rxcr_q;
  assign data_cfg     = dcfg_q;
  assign station_addr = sta_q;
  assign mcast_hash   = mch_q;

endmodule

// File: rtl/nic_regbank_chk.sv
module nic_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic       irq,
  input logic       tx_go,
  input logic       host_wr,
  input logic [3:0] host_addr,
  input logic [7:0] host_wdata,
  input logic [6:0] evt_set
);

  a_r3_no_status_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[6:0] == 7'd0) |-> !irq);

  a_r3_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (imr[6:0] == 7'd0) |-> !irq);

  a_r4_reset_bit_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(isr[7]));

  a_r5_run_clears_reset_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 4'd0 && !host_wdata[0]) |=> !isr[7]);

  a_r7_send_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  a_r7_send_flags_status: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> isr[1]);

  a_r11_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((isr[6:0] & $past(evt_set)) == $past(evt_set)));

endmodule

bind nic_regbank nic_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .isr(isr_q), .imr(imr_q), .irq(irq),
  .tx_go(tx_go), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .evt_set(evt_set)
);

// File: tb/tb_nic_regbank.sv
module tb_nic_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic [6:0]  evt_set = 7'd0;
  logic        irq, tx_go;
  logic [15:0] tx_addr, tx_len, ring_start, ring_stop, dma_addr, dma_count;
  logic [7:0]  rx_cfg, data_cfg;
  logic [47:0] station_addr;
  logic [63:0] mcast_hash;

  int total = 0;
  int bad = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_regbank dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
    .irq(irq), .tx_go(tx_go), .tx_addr(tx_addr), .tx_len(tx_len),
    .ring_start(ring_start), .ring_stop(ring_stop), .dma_addr(dma_addr),
    .dma_count(dma_count), .rx_cfg(rx_cfg), .data_cfg(data_cfg),
    .station_addr(station_addr), .mcast_hash(mcast_hash)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic pulse_evt(input logic [6:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = 7'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, rv); check(rv == 8'h00, "R1 cmd", rv, 8'h00);
    rd(4'h7, rv); check(rv == 8'h80, "R1 status", rv, 8'h80);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(tx_go == 1'b0, "R1 tx_go", tx_go, 0);
    check(ring_start == 16'h0 && dma_count == 16'h0 && station_addr == 48'h0, "R1 stored", ring_start, 0);

    // R4: bit 7 not cleared by write-one
    wr(4'h7, 8'hff);
    rd(4'h7, rv); check(rv == 8'h80, "R4 bit7 sticky", rv, 8'h80);
    // R3: bit 7 never interrupts
    wr(4'hf, 8'hff);
    check(irq == 1'b0, "R3 bit7 no irq", irq, 0);
    wr(4'hf, 8'h00);

    // R9/R5: full map sweep with stop set, all pages
    for (int p = 0; p < 4; p++) begin
      wr(4'h0, 8'(p << 6) | 8'h01);
      for (int a = 1; a < 16; a++) begin
        logic [7:0] e;
        e = 8'h00;
        if (p == 0 && a == 7)  e = 8'h80;
        if (p == 0 && a == 10) e = 8'h50;
        if (p == 0 && a == 11) e = 8'h43;
        rd(4'(a), rv);
        check(rv == e, "R9 map slot", {p[7:0], 4'(a), rv}, e);
      end
    end
    wr(4'h0, 8'h01);
    rd(4'h7, rv); check(rv == 8'h80, "R5 stop set keeps bit7", rv, 8'h80);
    wr(4'h0, 8'h00);
    rd(4'h7, rv); check(rv == 8'h00, "R5 run clears bit7", rv, 8'h00);

    // R10 ring pages
    wr(4'h1, 8'h46); wr(4'h2, 8'h80);
    check(ring_start == 16'h4600, "R10 ring_start", ring_start, 16'h4600);
    check(ring_stop == 16'h8000, "R10 ring_stop", ring_stop, 16'h8000);
    rd(4'h1, rv); check(rv == 8'h00, "R9 page0 0x1 reads 0", rv, 0);
    wr(4'h0, 8'h80);
    rd(4'h1, rv); check(rv == 8'h46, "R10 page2 start", rv, 8'h46);
    rd(4'h2, rv); check(rv == 8'h80, "R10 page2 stop", rv, 8'h80);

    // R2 page 1 storage
    wr(4'h0, 8'h40);
    for (int a = 1; a < 16; a++) wr(4'(a), 8'(8'h10 + a * 3));
    for (int a = 1; a < 16; a++) begin
      rd(4'(a), rv); check(rv == 8'(8'h10 + a * 3), "R2 page1 readback", rv, 8'(8'h10 + a * 3));
    end
    check(station_addr == {8'h22, 8'h1f, 8'h1c, 8'h19, 8'h16, 8'h13}, "R2 station bus", station_addr,
          {8'h22, 8'h1f, 8'h1c, 8'h19, 8'h16, 8'h13});
    check(mcast_hash[7:0] == 8'h28 && mcast_hash[63:56] == 8'h3d, "R2 hash bus", mcast_hash, 0);
    rd(4'h0, rv); check(rv == 8'h40, "R2 offset0 is cmd", rv, 8'h40);
    wr(4'h0, 8'h00);
    rd(4'h3, rv); check(rv == 8'h00, "R2 boundary untouched", rv, 0);
    check(ring_start == 16'h4600 && dma_count == 16'h0 && rx_cfg == 8'h0, "R2 page0 untouched", ring_start, 16'h4600);
    wr(4'h3, 8'h5a);
    rd(4'h3, rv); check(rv == 8'h5a, "R2 boundary page0", rv, 8'h5a);

    // R8 split loads
    wr(4'h8, 8'h34); wr(4'h9, 8'h12);
    check(dma_addr == 16'h1234, "R8 rsar both", dma_addr, 16'h1234);
    wr(4'h8, 8'hcd);
    check(dma_addr == 16'h12cd, "R8 rsar low only", dma_addr, 16'h12cd);
    rd(4'h9, rv); check(rv == 8'h12, "R8 rsar hi read", rv, 8'h12);
    rd(4'h8, rv); check(rv == 8'hcd, "R8 rsar lo read", rv, 8'hcd);
    wr(4'hb, 8'h77);
    check(dma_count == 16'h7700, "R8 rcnt hi only", dma_count, 16'h7700);
    wr(4'hc, 8'h1c); wr(4'he, 8'h49);
    check(rx_cfg == 8'h1c && data_cfg == 8'h49, "R2 cfg bytes", {rx_cfg, data_cfg}, 16'h1c49);

    // R6 zero-count remote DMA
    wr(4'h0, 8'h0a);
    rd(4'h7, rv); check(rv == 8'h00, "R6 nonzero count no set", rv, 0);
    wr(4'ha, 8'h00); wr(4'hb, 8'h00);
    wr(4'h0, 8'h09);
    rd(4'h7, rv); check(rv == 8'h00, "R6 stop set no set", rv, 0);
    wr(4'h0, 8'h0a);
    rd(4'h7, rv); check(rv == 8'h40, "R6 remote read zero", rv, 8'h40);
    wr(4'h7, 8'h40);
    wr(4'h0, 8'h12);
    rd(4'h7, rv); check(rv == 8'h40, "R6 remote write zero", rv, 8'h40);
    wr(4'h7, 8'h7f);

    // R7 transmit
    wr(4'h4, 8'h40); wr(4'h5, 8'hea); wr(4'h6, 8'h05);
    wr(4'h0, 8'h05);
    check(tx_go == 1'b0, "R7 stop set no send", tx_go, 0);
    rd(4'h0, rv); check(rv == 8'h05, "R7 stop set keeps bit2", rv, 8'h05);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'h0; host_wdata = 8'h06;
    @(negedge clk);
    host_wr = 1'b0;
    check(tx_go == 1'b1, "R7 tx_go", tx_go, 1);
    check(tx_addr == 16'h4000, "R7 tx_addr", tx_addr, 16'h4000);
    check(tx_len == 16'h05ea, "R7 tx_len", tx_len, 16'h05ea);
    rd(4'h7, rv); check(rv == 8'h02, "R7 status bit1", rv, 8'h02);
    rd(4'h4, rv); check(rv == 8'h01, "R7 tsr", rv, 8'h01);
    rd(4'h0, rv); check(rv == 8'h02, "R7 cmd bit2 cleared", rv, 8'h02);
    @(negedge clk);
    check(tx_go == 1'b0, "R7 tx_go one cycle", tx_go, 0);
    wr(4'h5, 8'h10);
    wr(4'h0, 8'h04);
    check(tx_len == 16'h0510, "R8 tcnt low only", tx_len, 16'h0510);
    wr(4'h7, 8'h7f);

    // R4 sweep over every clear pattern
    for (int v = 0; v < 128; v++) begin
      pulse_evt(7'h7f);
      wr(4'h7, 8'(v));
      rd(4'h7, rv);
      check(rv == {1'b0, ~7'(v)}, "R4 clear pattern", rv, {1'b0, ~7'(v)});
      wr(4'h7, 8'h7f);
    end

    // R11 each event bit, and set beats clear
    for (int b = 0; b < 7; b++) begin
      pulse_evt(7'(1 << b));
      rd(4'h7, rv); check(rv == 8'(1 << b), "R11 event bit", rv, 8'(1 << b));
      @(negedge clk);
      host_wr = 1'b1; host_addr = 4'h7; host_wdata = 8'h7f; evt_set = 7'(1 << b);
      @(negedge clk);
      host_wr = 1'b0; evt_set = 7'd0;
      rd(4'h7, rv); check(rv == 8'(1 << b), "R11 set wins", rv, 8'(1 << b));
      wr(4'h7, 8'h7f);
    end

    // R3 interrupt sweep
    for (int k = 0; k < 4; k++) begin
      logic [6:0] pat;
      pat = (k == 0) ? 7'h01 : (k == 1) ? 7'h40 : (k == 2) ? 7'h2a : 7'h55;
      wr(4'h7, 8'h7f);
      pulse_evt(pat);
      for (int m = 0; m < 256; m++) begin
        wr(4'hf, 8'(m));
        check(irq == (|(pat & 7'(m))), "R3 irq gating", irq, |(pat & 7'(m)));
      end
    end
    wr(4'hf, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule